// File: doc/BRIEF.md
# Dual-Port Four-Word Register File

This block is a small storage array of four words, each four bits wide. It has a write port and a read port that work independently, so one word can be updated while another word, or the same one, is read in the same cycle. Writes are captured on the rising clock edge. A combinational bypass returns the incoming data when the read targets the word being written, so the read port sees a write as if the array were transparent.

The read side gates its output with an active-high valid flag. This flag stands in for a three-state driver. While the read port is disabled, the data lines are held at zero. Several instances can then be OR-ed onto one shared bus to build a deeper memory, up to 512 words, with the enable decode placed outside the block. Both port enables are active-low. An active-high synchronous reset clears the array.

Top module: `quad_regfile`

## Requirements
- R1: After a clock edge with `rst` high, every word reads back as zero.
- R2: When `wr_n` is low at a rising edge (and `rst` is low), the word at `wr_addr` takes `wr_data` unchanged, with no bit inversion, and holds it afterwards.
- R3: When `wr_n` is high, no stored word changes, whatever `wr_addr` and `wr_data` do.
- R4: A read of an address other than the one being written returns the word stored before the current edge.
- R5: When `wr_n` and `rd_n` are both low, `rst` is low and `rd_addr` equals `wr_addr`, `rd_data` equals the live `wr_data` in the same cycle.
- R6: When `rd_n` is high, `rd_valid` is 0 and `rd_data` is all zeros.
- R7: When `rd_n` is low, `rd_valid` is 1 and `rd_data` carries the selected word.
- R8: Reset has priority over a write in the same cycle: the word is not stored and the bypass of R5 is suppressed while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write enable, active low |
| wr_addr | input | 2 | Word selected for writing |
| wr_data | input | 4 | Data to store |
| rd_n | input | 1 | Read enable, active low |
| rd_addr | input | 2 | Word selected for reading |
| rd_data | output | 4 | Read word, zero while disabled |
| rd_valid | output | 1 | High while the read port drives data |

## Verification
The bench reads the word being written in the same cycle. A design without the bypass would return the old contents there, one cycle stale. It toggles address and data with the write enable high, which exposes any write decode that ignores the enable and corrupts a word. It disables the read port while the selected word is nonzero, which catches outputs that leak data onto the shared bus. It also asserts reset together with a write, which shows whether the write wins or the bypass leaks during reset.

// File: rtl/quad_regfile_pkg.sv
package quad_regfile_pkg;
    localparam int unsigned QRF_WORDS = 4;
    localparam int unsigned QRF_WIDTH = 4;
endpackage

// File: rtl/quad_regfile_store.sv
module quad_regfile_store
    import quad_regfile_pkg::*;
#(
    parameter int unsigned WORDS  = QRF_WORDS,
    parameter int unsigned WIDTH  = QRF_WIDTH,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [WIDTH-1:0]             wr_data,
    output logic [WORDS-1:0][WIDTH-1:0]  mem
);
    typedef struct packed {
        logic [WORDS-1:0][WIDTH-1:0] words;
    } store_t;

    store_t st_d, st_q;
    logic [WORDS-1:0] hit_d;

    for (genvar g = 0; g < WORDS; g++) begin : g_dec
        assign hit_d[g] = wr_en && (wr_addr == ADDR_W'(g));
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (hit_d[i]) st_d.words[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mem = st_q.words;
endmodule

// File: rtl/quad_regfile_rdport.sv
module quad_regfile_rdport
    import quad_regfile_pkg::*;
#(
    parameter int unsigned WORDS  = QRF_WORDS,
    parameter int unsigned WIDTH  = QRF_WIDTH,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic [WORDS-1:0][WIDTH-1:0]  mem,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [WIDTH-1:0]             wr_data,
    input  logic                         rd_n,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [WIDTH-1:0]             rd_data,
    output logic                         rd_valid
);
    logic             byp_d;
    logic [WIDTH-1:0] word_d;

    always_comb begin
        byp_d  = wr_en && (wr_addr == rd_addr);
        word_d = byp_d ? wr_data : mem[rd_addr];
        rd_valid = !rd_n;
        rd_data  = rd_n ? '0 : word_d;
    end
endmodule

// File: rtl/quad_regfile.sv
module quad_regfile
    import quad_regfile_pkg::*;
#(
    parameter int unsigned WORDS  = QRF_WORDS,
    parameter int unsigned WIDTH  = QRF_WIDTH,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_valid
);
    logic                        wr_live;
    logic [WORDS-1:0][WIDTH-1:0] mem_w;

    assign wr_live = !wr_n && !rst;

    quad_regfile_store #(.WORDS(WORDS), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_live),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mem     (mem_w)
    );

    quad_regfile_rdport #(.WORDS(WORDS), .WIDTH(WIDTH)) u_rd (
        .mem      (mem_w),
        .wr_en    (wr_live),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_n     (rd_n),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/quad_regfile_chk.sv
module quad_regfile_chk #(
    parameter int unsigned WORDS  = 4,
    parameter int unsigned WIDTH  = 4,
    localparam int unsigned ADDR_W = $clog2(WORDS)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_n,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [WIDTH-1:0]            wr_data,
    input logic                        rd_n,
    input logic [ADDR_W-1:0]           rd_addr,
    input logic [WIDTH-1:0]            rd_data,
    input logic                        rd_valid,
    input logic [WORDS-1:0][WIDTH-1:0] mem
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (mem == '0));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_n) |=> (mem[$past(wr_addr)] == $past(wr_data)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_n) |=> $stable(mem));

    // R5
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !rd_n && (rd_addr == wr_addr)) |-> (rd_data == wr_data));

    // R6
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        rd_n |-> (!rd_valid && (rd_data == '0)));

    // R7
    valid_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n) |-> rd_valid);
endmodule

bind quad_regfile quad_regfile_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_n     (wr_n),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_n     (rd_n),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .mem      (mem_w)
);

// File: tb/test_quad_regfile.sv
`timescale 1ns/1ps
module test_quad_regfile;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1;
    logic [1:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic       rd_n = 1'b1;
    logic [1:0] rd_addr = '0;
    logic [3:0] rd_data;
    logic       rd_valid;

    typedef struct {
        logic [3:0] data;
        logic       valid;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    logic [3:0] model [4];
    int         checks = 0;
    int         failures = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    quad_regfile i_quad_regfile (
        .clk(clk), .rst(rst), .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_n(rd_n), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Driver: applies one cycle of stimulus and pushes the expected read result.
    task automatic step(input logic r, input logic wn, input logic [1:0] wa,
                        input logic [3:0] wd, input logic rn, input logic [1:0] ra,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; wr_n = wn; wr_addr = wa; wr_data = wd; rd_n = rn; rd_addr = ra;
        e.valid = !rn;
        if (rn)                            e.data = 4'h0;
        else if (!wn && !r && wa == ra)    e.data = wd;
        else                               e.data = model[ra];
        e.tag = tag;
        sb.push_back(e);
        if (r) begin
            for (int i = 0; i < 4; i++) model[i] = 4'h0;
        end else if (!wn) begin
            model[wa] = wd;
        end
    endtask

    // Monitor: compares outputs away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (rd_data !== e.data || rd_valid !== e.valid) begin
                    failures++;
                    $display("FAIL %s: actual data=%h valid=%b expected data=%h valid=%b",
                             e.tag, rd_data, rd_valid, e.data, e.valid);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 4'hx;
        // Reset held: output disabled (R6)
        step(1, 1, 0, 0, 1, 0, "R6 during reset");
        step(1, 1, 0, 0, 1, 0, "R6 during reset");
        // R1: every word reads zero after reset
        for (int a = 0; a < 4; a++) step(0, 1, 0, 0, 0, 2'(a), "R1 reset value");
        // R2: fill with distinct patterns, read back
        step(0, 0, 0, 4'hA, 1, 0, "R6 disabled read");
        step(0, 0, 1, 4'h5, 1, 0, "R6 disabled read");
        step(0, 0, 2, 4'hC, 1, 0, "R6 disabled read");
        step(0, 0, 3, 4'h3, 1, 0, "R6 disabled read");
        for (int a = 0; a < 4; a++) step(0, 1, 0, 0, 0, 2'(a), "R2 stored word");
        // R4: write one address while reading another
        step(0, 0, 1, 4'h9, 0, 2, "R4 other address");
        step(0, 0, 2, 4'h7, 0, 1, "R4 other address");
        step(0, 1, 0, 0, 0, 2, "R2 after overlap");
        // R5: same-address read sees live data
        step(0, 0, 3, 4'hE, 0, 3, "R5 bypass");
        step(0, 0, 3, 4'h1, 0, 3, "R5 bypass");
        step(0, 1, 0, 0, 0, 3, "R2 after bypass");
        // R3: enable high, address and data toggle
        for (int k = 0; k < 8; k++) step(0, 1, 2'(k), 4'(k * 5 + 2), 1, 0, "R3 idle");
        for (int a = 0; a < 4; a++) step(0, 1, 2'(a), 4'hF, 0, 2'(a), "R3 words held");
        // R6/R7: disabled while the word is nonzero, then enabled
        step(0, 1, 0, 0, 1, 0, "R6 gated output");
        step(0, 1, 0, 0, 0, 0, "R7 enabled output");
        // R8: reset together with a same-address write
        step(0, 0, 2, 4'hB, 0, 0, "R4 other address");
        step(1, 0, 2, 4'hF, 0, 2, "R8 no bypass in reset");
        for (int a = 0; a < 4; a++) step(0, 1, 0, 0, 0, 2'(a), "R8 reset wins");
        repeat (3) @(negedge clk);
        #3;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule